// File: doc/BRIEF.md
# Paged Management Register Window

This block is the byte-addressed management store that sits behind a two-wire serial target in a pluggable module. The serial engine turns host transactions into single-byte accesses on a simple port: an 8-bit address, a write strobe with write data, and a read strobe. Read data comes back one clock later. The block holds everything the host sees through that port.

The address space splits in two halves. The low half, offsets 00h to 7Fh, is one fixed region that the host can always reach. Two bytes at the top of this region choose what the high half shows. The high half, 80h to FFh, is a window onto one 128-byte page. Some page numbers also have a second-level bank choice.

Each page falls into one of three classes:
- Fixed-content pages, whose bytes are computed constants. Host writes to them are dropped.
- Writable pages, backed by flops.
- Unimplemented page/bank combinations, which read as zero and discard writes.

A module-select input, active low, gates every access. While it is high, the block behaves as if the port were idle.

Top module: `mgmt_win`

## Requirements
- R1: After synchronous reset, rd_data is 00h, every low-region byte is 00h (so page select and bank select are 0), and all bytes of pages 03h and 10h are 00h.
- R2: Addresses 00h–7Fh read and write one 128-byte region, whatever page and bank are selected.
- R3: Low-region byte 7Fh is the page-select register and byte 7Eh is the bank-select register. Both are read and written like any low-region byte.
- R4: When the selected page is 00h, 01h or 02h, a read of address A in 80h–FFh returns ((page×16) mod 256) XOR (A−80h) XOR A5h. Writes there change nothing.
- R5: Page 03h is a 128-byte read/write area; a byte written there reads back unchanged.
- R6: Page 10h with bank 0 is a 128-byte read/write area. Page 11h with bank 0 returns the same computed content as R4 (using page 11h) and ignores writes.
- R7: A high-half read returns 00h when the selected page is anything other than 00h–03h, 10h or 11h, or when it is 10h or 11h with a nonzero bank. Writes in these cases alter no storage.
- R8: While mod_sel_n is 1, wr_en changes no storage and rd_en leaves rd_data unchanged.
- R9: rd_data updates on the clock edge that samples a valid read (rd_en=1, mod_sel_n=0). It holds its value on every other cycle.
- R10: When a read and a write to the same address fall in one cycle, the read returns the value from before the write.
- R11: Bank select has no effect on pages 00h–03h. Pages 03h and 10h are separate storage, so a write at one offset of one page leaves the same offset of the other page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_sel_n | input | 1 | Module select, active low; high blocks all access |
| addr | input | 8 | Byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte, valid the clock after rd_en |

## Verification
The window is tested with every page class selected in turn:
- the fixed pages, under two different bank values;
- both writable pages, at the same offsets, to show they are separate storage;
- page 11h in bank 0, and then pages 10h and 11h in bank 1;
- unimplemented page numbers.

A full sweep of all 128 page-03h offsets with an address-dependent pattern exposes aliasing and decode slips. Writes to the fixed and gated pages are followed by read-back, which shows that the write was dropped. Deselected accesses, idle cycles and same-cycle read/write pairs separate the read-latency and hold rules from the storage rules.

// File: rtl/mgmt_win_pkg.sv
package mgmt_win_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int HALF   = 128;
    localparam int OFF_W  = 7;

    localparam logic [OFF_W-1:0] PAGE_SEL_OFF = 7'h7F;
    localparam logic [OFF_W-1:0] BANK_SEL_OFF = 7'h7E;

    localparam logic [DATA_W-1:0] BANKED_PAGE_A = 8'h10;
    localparam logic [DATA_W-1:0] BANKED_PAGE_B = 8'h11;
    localparam logic [DATA_W-1:0] ROM_SEED      = 8'hA5;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        T_LOWER  = 2'd0,
        T_ROM    = 2'd1,
        T_RWPAGE = 2'd2,
        T_NONE   = 2'd3
    } tgt_e;

    // Page numbers of the writable pages, by index.
    function automatic byte_t rw_page_id(input int idx);
        return (idx == 0) ? 8'h03 : 8'h10;
    endfunction

    function automatic logic is_banked(input byte_t page);
        return (page == BANKED_PAGE_A) || (page == BANKED_PAGE_B);
    endfunction

    function automatic logic is_rom_page(input byte_t page);
        return (page <= 8'h02) || (page == BANKED_PAGE_B);
    endfunction

    // Computed content of the fixed pages.
    function automatic byte_t rom_byte(input byte_t page, input logic [OFF_W-1:0] off);
        byte_t shifted;
        shifted = {page[3:0], 4'h0};
        return shifted ^ {1'b0, off} ^ ROM_SEED;
    endfunction

endpackage

// File: rtl/mgmt_win_ram.sv
module mgmt_win_ram
    import mgmt_win_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [W-1:0]              wdata,
    output logic [DEPTH-1:0][W-1:0]   mem_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // R5: a write lands at its address and is visible on the next cycle
    a_r5_store_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> mem_q[$past(waddr)] == $past(wdata));

    // R8/R7: storage only moves when its write enable was raised
    a_r7_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem_q));

endmodule

// File: rtl/mgmt_win_decode.sv
module mgmt_win_decode
    import mgmt_win_pkg::*;
#(
    parameter int N_RW     = 2,
    parameter int RW_IDX_W = 1
) (
    input  logic [ADDR_W-1:0]   addr,
    input  byte_t               page_sel,
    input  byte_t               bank_sel,
    output tgt_e                tgt,
    output logic [RW_IDX_W-1:0] rw_idx,
    output logic [OFF_W-1:0]    off
);

    logic                hit;
    logic [RW_IDX_W-1:0] hit_idx;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < N_RW; i++) begin
            if (page_sel == rw_page_id(i)) begin
                hit     = 1'b1;
                hit_idx = RW_IDX_W'(i);
            end
        end
    end

    always_comb begin
        off    = addr[OFF_W-1:0];
        rw_idx = hit_idx;
        if (!addr[ADDR_W-1]) begin
            tgt = T_LOWER;
        end else if (is_banked(page_sel) && (bank_sel != 8'h00)) begin
            tgt = T_NONE;
        end else if (is_rom_page(page_sel)) begin
            tgt = T_ROM;
        end else if (hit) begin
            tgt = T_RWPAGE;
        end else begin
            tgt = T_NONE;
        end
    end

endmodule

// File: rtl/mgmt_win.sv
module mgmt_win
    import mgmt_win_pkg::*;
#(
    parameter int N_RW = 2,
    localparam int RW_IDX_W = (N_RW > 1) ? $clog2(N_RW) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mod_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    logic                          wr_ok;
    logic                          rd_ok;
    logic [HALF-1:0][DATA_W-1:0]   lower_q;
    logic [N_RW-1:0][HALF-1:0][DATA_W-1:0] rw_q;
    logic [N_RW-1:0]               rw_we;
    byte_t                         page_sel;
    byte_t                         bank_sel;
    tgt_e                          tgt;
    logic [RW_IDX_W-1:0]           rw_idx;
    logic [OFF_W-1:0]              off;
    byte_t                         rd_next;

    assign wr_ok = wr_en && !mod_sel_n;
    assign rd_ok = rd_en && !mod_sel_n;

    assign page_sel = lower_q[PAGE_SEL_OFF];
    assign bank_sel = lower_q[BANK_SEL_OFF];

    mgmt_win_decode #(
        .N_RW     (N_RW),
        .RW_IDX_W (RW_IDX_W)
    ) u_decode (
        .addr     (addr),
        .page_sel (page_sel),
        .bank_sel (bank_sel),
        .tgt      (tgt),
        .rw_idx   (rw_idx),
        .off      (off)
    );

    mgmt_win_ram #(
        .DEPTH (HALF),
        .W     (DATA_W)
    ) u_lower (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok && (tgt == T_LOWER)),
        .waddr (off),
        .wdata (wr_data),
        .mem_q (lower_q)
    );

    for (genvar g = 0; g < N_RW; g++) begin : g_rw
        assign rw_we[g] = wr_ok && (tgt == T_RWPAGE) && (rw_idx == RW_IDX_W'(g));

        mgmt_win_ram #(
            .DEPTH (HALF),
            .W     (DATA_W)
        ) u_page (
            .clk   (clk),
            .rst   (rst),
            .we    (rw_we[g]),
            .waddr (off),
            .wdata (wr_data),
            .mem_q (rw_q[g])
        );
    end

    always_comb begin
        case (tgt)
            T_LOWER:  rd_next = lower_q[off];
            T_ROM:    rd_next = rom_byte(page_sel, off);
            T_RWPAGE: rd_next = rw_q[rw_idx][off];
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_ok) begin
            rd_data <= rd_next;
        end
    end

    // R9: output only moves on a valid read
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && !mod_sel_n) |=> $stable(rd_data));

    // R8: deselected writes leave the select registers alone
    a_r8_desel_no_write: assert property (@(posedge clk) disable iff (rst)
        (mod_sel_n && wr_en) |=> ($stable(page_sel) && $stable(bank_sel)));

    // R3: page-select register takes the written byte
    a_r3_page_sel_write: assert property (@(posedge clk) disable iff (rst)
        (!mod_sel_n && wr_en && addr == 8'h7F) |=> page_sel == $past(wr_data));

    // R7: a banked page in a nonzero bank reads as zero
    a_r7_bank_gate: assert property (@(posedge clk) disable iff (rst)
        (!mod_sel_n && rd_en && addr[7] && is_banked(page_sel) && bank_sel != 8'h00)
        |=> rd_data == 8'h00);

    // R4: fixed pages return their computed content
    a_r4_fixed_content: assert property (@(posedge clk) disable iff (rst)
        (!mod_sel_n && rd_en && addr[7] && page_sel <= 8'h02)
        |=> rd_data == rom_byte($past(page_sel), $past(addr[OFF_W-1:0])));

endmodule

// File: tb/mgmt_win_bench.sv
module mgmt_win_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       mod_sel_n;
    logic [7:0] addr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       rd_en;
    logic [7:0] rd_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    int m_lower [128];
    int m_p3    [128];
    int m_p10   [128];
    int exp_rd;

    mgmt_win u_mgmt_win (
        .clk       (clk),
        .rst       (rst),
        .mod_sel_n (mod_sel_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data)
    );

    always #10 clk = ~clk;

    function automatic int model_read(input int a);
        int page, bank, o;
        if (a < 128) return m_lower[a];
        page = m_lower[127];
        bank = m_lower[126];
        o = a - 128;
        if ((page == 16 || page == 17) && bank != 0) return 0;
        if (page <= 2 || page == 17) return ((page * 16) % 256) ^ o ^ 8'hA5;
        if (page == 3) return m_p3[o];
        if (page == 16) return m_p10[o];
        return 0;
    endfunction

    task automatic model_write(input int a, input int d);
        int page, bank;
        page = m_lower[127];
        bank = m_lower[126];
        if (a < 128) m_lower[a] = d;
        else if (page == 3) m_p3[a - 128] = d;
        else if (page == 16 && bank == 0) m_p10[a - 128] = d;
    endtask

    task automatic step(input bit sel_n, input int a, input bit we, input int wd,
                        input bit re, input string req);
        @(negedge clk);
        mod_sel_n = sel_n;
        addr      = a[7:0];
        wr_en     = we;
        wr_data   = wd[7:0];
        rd_en     = re;
        if (!sel_n && re) exp_rd = model_read(a);
        if (!sel_n && we) model_write(a, wd);
        @(posedge clk);
        #1;
        vectors++;
        if (rd_data !== exp_rd[7:0]) begin
            errors++;
            $display("FAIL %s: addr=%02h rd_data=%02h expected=%02h", req, a, rd_data, exp_rd[7:0]);
        end
    endtask

    task automatic wr(input int a, input int d, input string req);
        step(1'b0, a, 1'b1, d, 1'b0, req);
    endtask

    task automatic rd(input int a, input string req);
        step(1'b0, a, 1'b0, 0, 1'b1, req);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            m_lower[i] = 0; m_p3[i] = 0; m_p10[i] = 0;
        end
        exp_rd = 0;
        rst = 1'b1; mod_sel_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        step(1'b0, 0, 1'b0, 0, 1'b0, "R1");
        rd(8'h7F, "R1"); rd(8'h7E, "R1"); rd(8'h20, "R1");
        wr(8'h7F, 3, "R3");
        rd(8'h80, "R1"); rd(8'hFF, "R1");

        // R2 low region
        wr(8'h10, 8'h5A, "R2"); wr(8'h00, 8'hC3, "R2");
        rd(8'h10, "R2"); rd(8'h00, "R2");

        // R3 select registers
        wr(8'h7F, 8'h02, "R3"); rd(8'h7F, "R3");
        wr(8'h7E, 8'h01, "R3"); rd(8'h7E, "R3");

        // R4 fixed pages, R11 bank ignored there
        rd(8'h80, "R4"); rd(8'h85, "R4"); rd(8'hFF, "R4");
        wr(8'h85, 8'h00, "R4"); rd(8'h85, "R4");
        wr(8'h7E, 0, "R11"); rd(8'h85, "R11");
        wr(8'h7F, 0, "R4"); rd(8'h90, "R4");
        wr(8'h7F, 1, "R4"); rd(8'hA1, "R4");

        // R5 page 03 sweep, R11 with bank 2
        wr(8'h7F, 3, "R5"); wr(8'h7E, 2, "R11");
        for (int i = 0; i < 128; i++) wr(128 + i, (i * 7 + 3) % 256, "R5");
        for (int i = 0; i < 128; i++) rd(128 + i, "R5");

        // R6 page 10 bank 0, R11 separate storage
        wr(8'h7E, 0, "R6"); wr(8'h7F, 8'h10, "R6");
        rd(8'h84, "R11");
        wr(8'h84, 8'h9E, "R6"); rd(8'h84, "R6");
        wr(8'h7F, 3, "R11"); rd(8'h84, "R11");
        wr(8'h7F, 8'h11, "R6");
        rd(8'h80, "R6"); rd(8'hC4, "R6");
        wr(8'hC4, 8'h11, "R6"); rd(8'hC4, "R6");

        // R7 gated bank and unsupported pages
        wr(8'h7E, 1, "R7"); rd(8'hC4, "R7");
        wr(8'h7F, 8'h10, "R7"); rd(8'h84, "R7");
        wr(8'h84, 8'h77, "R7");
        wr(8'h7E, 0, "R7"); rd(8'h84, "R7");
        wr(8'h7F, 5, "R7"); rd(8'h90, "R7");
        wr(8'h90, 8'h44, "R7"); rd(8'h90, "R7");
        wr(8'h7F, 8'h20, "R7"); rd(8'hFF, "R7");

        // R8 deselected
        rd(8'h10, "R8");
        step(1'b1, 8'h10, 1'b1, 8'hEE, 1'b0, "R8");
        step(1'b1, 8'h00, 1'b0, 0, 1'b1, "R8");
        step(1'b1, 8'h7F, 1'b1, 3, 1'b1, "R8");
        rd(8'h10, "R8"); rd(8'h7F, "R8");

        // R9 hold on idle cycles
        rd(8'h00, "R9");
        step(1'b0, 8'h10, 1'b0, 0, 1'b0, "R9");
        step(1'b0, 8'h10, 1'b0, 0, 1'b0, "R9");

        // R10 same-cycle read and write
        step(1'b0, 8'h10, 1'b1, 8'h3C, 1'b1, "R10");
        rd(8'h10, "R10");
        wr(8'h7F, 3, "R10");
        step(1'b0, 8'h81, 1'b1, 8'hB2, 1'b1, "R10");
        rd(8'h81, "R10");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule